// File: doc/BRIEF.md
# Superframe Fs Data-Link Transmit Stack

This block holds a five-byte transmit stack that host software programs through a simple register write port, and turns it into the serial Fs bit of a 72-frame subscriber-carrier superframe. The Fs bit is sent in every even frame, so one superframe carries 36 Fs bits. The first 12 are the sync pattern, taken from the low six bits of the first two stack bytes. The last 24 are data-link bits, taken from the remaining three bytes, most significant bit first.

Host writes land in a shadow copy. At the first frame of each superframe, the shadow copy is moved into a working register, so a superframe never mixes old and new data. Contents that are not rewritten are sent again in the next superframe. At the same frame boundary, a sticky ready flag is set and an interrupt pulse is raised to tell the host that the next update window is open. A status read clears the flag. Insertion runs only while the enable input is 1 and the mode field selects stack insertion.

Top module: `dlk_stack_tx`

## Requirements
- R1: After reset, `stack_rdy`, `stack_irq` and `fs_vld` are 0. The stack holds the idle default: bytes 0 and 1 = 8'h07, byte 2 = 8'h00, byte 3 = 8'h08, byte 4 = 8'h1F.
- R2: Insertion is active only when `ins_en` = 1 and `ins_mode[1:0]` = 2'b10. Bit 2 of the mode is a don't-care. While insertion is inactive, `fs_vld` stays 0 and the ready flag is not set.
- R3: A `frame_stb` with an even `sf_pos` below 72 makes `fs_vld` = 1 in the following cycle. In that cycle `fs_bit` carries Fs bit number `sf_pos/2`. Odd positions give `fs_vld` = 0.
- R4: The 36-bit Fs sequence, first bit first, is: byte 0 bits 5..0, byte 1 bits 5..0, then bytes 2, 3 and 4 each from bit 7 down to bit 0. Byte n is written with `host_addr` = n.
- R5: Writes to `host_addr` 5, 6 or 7 change no stack byte.
- R6: The sequence is captured at the strobe with `sf_pos` = 0. A write in that same cycle or later goes out in the next superframe. Bytes that are not rewritten are sent again unchanged.
- R7: The strobe with `sf_pos` = 0, while insertion is active, sets `stack_rdy` in the next cycle. `stack_irq` pulses for that one cycle only if the flag was clear before.
- R8: `stat_rd` clears `stack_rdy` in the next cycle. If the read falls in the same cycle as the setting strobe, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Stack byte write strobe |
| host_addr | input | 3 | Stack byte index (0 to 4 valid) |
| host_wdata | input | 8 | Byte to write |
| stat_rd | input | 1 | Status read, clears the ready flag |
| frame_stb | input | 1 | One-cycle pulse per frame |
| sf_pos | input | 7 | Frame number within the superframe, 0 to 71 |
| ins_en | input | 1 | Stack insertion enable |
| ins_mode | input | 3 | Insertion mode, 2'b10 in bits 1..0 selects the stack |
| fs_bit | output | 1 | Serial Fs bit |
| fs_vld | output | 1 | Qualifies `fs_bit` for an even frame |
| stack_rdy | output | 1 | Sticky update-window flag |
| stack_irq | output | 1 | One-cycle pulse when the flag sets |

## Verification
Two functions can fall in the same cycle: a host write and the superframe-start capture. Likewise, a status read can coincide with the flag setting. The bench provokes both on purpose. It places a write to a D-bit byte, and a read, on the very strobe with position 0, and also on random strobes during randomized superframes. The bench model judges the result by capturing the sequence before applying that cycle's write, and by letting a set win over a clear. So the written byte must show up only one superframe later, and the flag must stay high.

// File: rtl/dlk_pkg.sv
// Shared constants and types for the Fs data-link transmit stack.
// Assumes a superframe of twice as many frames as there are Fs bits.
package dlk_pkg;
    localparam int REGS      = 5;
    localparam int BYTE_W    = 8;
    localparam int SYNC_W    = 6;
    localparam int FS_BITS   = 2 * SYNC_W + (REGS - 2) * BYTE_W;
    localparam int SF_FRAMES = 2 * FS_BITS;
    localparam int POS_W     = $clog2(SF_FRAMES);
    localparam int ADDR_W    = $clog2(REGS) > 0 ? $clog2(REGS) : 1;
    localparam int IDX_W     = POS_W - 1;

    typedef logic [REGS-1:0][BYTE_W-1:0] stack_t;

    // Idle default: two sync bytes, idle line-switch code, spoiler pattern
    localparam stack_t STACK_RST = {8'h1F, 8'h08, 8'h00, 8'h07, 8'h07};

    // Flatten the stack into the transmit order, first bit at the top
    function automatic logic [FS_BITS-1:0] build_fs(input stack_t s);
        logic [FS_BITS-1:0] v;
        v = '0;
        v[FS_BITS-1 -: SYNC_W]          = s[0][SYNC_W-1:0];
        v[FS_BITS-1-SYNC_W -: SYNC_W]   = s[1][SYNC_W-1:0];
        for (int r = 2; r < REGS; r++) begin
            v[(REGS-1-r)*BYTE_W +: BYTE_W] = s[r];
        end
        return v;
    endfunction
endpackage

// File: rtl/dlk_shadow_regs.sv
// Host-writable shadow copy of the stack bytes.
// Assumes one write per cycle; indices at or above REGS are discarded.
module dlk_shadow_regs
    import dlk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output stack_t            shadow
);
    for (genvar i = 0; i < REGS; i++) begin : g_byte
        // Capture the host byte addressed to this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[i] <= STACK_RST[i];
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                shadow[i] <= wr_data;
            end
        end
    end

    // R5
    bad_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) >= REGS)) |=> $stable(shadow));
endmodule

// File: rtl/dlk_fs_serializer.sv
// Picks the Fs bit for each even frame from a per-superframe snapshot.
// Assumes sf_pos is sampled only with frame_stb; position 0 starts a superframe.
module dlk_fs_serializer
    import dlk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [POS_W-1:0] sf_pos,
    input  logic             active,
    input  stack_t           shadow,
    output logic             sof,
    output logic             fs_bit,
    output logic             fs_vld
);
    logic [FS_BITS-1:0] cur_q;
    logic [FS_BITS-1:0] sel_vec;
    logic [IDX_W-1:0]   idx;
    logic               take;
    logic               pick;

    // Decode superframe start, the even-frame take and the selected bit
    always_comb begin
        sof     = frame_stb && active && (sf_pos == '0);
        take    = frame_stb && active && !sf_pos[0] && (sf_pos < POS_W'(SF_FRAMES));
        idx     = sf_pos[POS_W-1:1];
        sel_vec = sof ? build_fs(shadow) : cur_q;
        pick    = take ? sel_vec[FS_BITS-1-int'(idx)] : 1'b0;
    end

    // Snapshot the shadow copy at the start of each superframe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= build_fs(STACK_RST);
        end else if (sof) begin
            cur_q <= build_fs(shadow);
        end
    end

    // Register the serial output and its qualifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_bit <= 1'b0;
            fs_vld <= 1'b0;
        end else begin
            fs_bit <= pick;
            fs_vld <= take;
        end
    end

    // R3
    even_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_vld |-> ($past(frame_stb) && !$past(sf_pos[0])));
    // R2
    inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !fs_vld);
    // R6
    snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(cur_q));
endmodule

// File: rtl/dlk_ready_ctl.sv
// Sticky update-window flag with clear-on-read and a set pulse.
// Assumes a set and a read in one cycle leave the flag set.
module dlk_ready_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic rd_clr,
    output logic rdy,
    output logic irq
);
    // Hold the flag; a set takes priority over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0;
        end else if (set_ev) begin
            rdy <= 1'b1;
        end else if (rd_clr) begin
            rdy <= 1'b0;
        end
    end

    // Pulse the interrupt when a set finds the flag clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= set_ev && !rdy;
        end
    end

    // R7
    rdy_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(set_ev));
    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rdy && !$past(rdy)));
    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !set_ev) |=> !rdy);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> rdy);
endmodule

// File: rtl/dlk_stack_tx.sv
// Top of the Fs data-link transmit stack: shadow bytes, serializer, ready flag.
// Assumes the caller supplies frame strobes and superframe positions.
module dlk_stack_tx
    import dlk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              stat_rd,
    input  logic              frame_stb,
    input  logic [POS_W-1:0]  sf_pos,
    input  logic              ins_en,
    input  logic [2:0]        ins_mode,
    output logic              fs_bit,
    output logic              fs_vld,
    output logic              stack_rdy,
    output logic              stack_irq
);
    stack_t shadow;
    logic   active;
    logic   sof;

    // Insertion runs only with the enable set and mode bits 1..0 = 10
    always_comb begin
        active = ins_en && (ins_mode[1:0] == 2'b10);
    end

    dlk_shadow_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr),
        .wr_addr (host_addr),
        .wr_data (host_wdata),
        .shadow  (shadow)
    );

    dlk_fs_serializer i_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .sf_pos    (sf_pos),
        .active    (active),
        .shadow    (shadow),
        .sof       (sof),
        .fs_bit    (fs_bit),
        .fs_vld    (fs_vld)
    );

    dlk_ready_ctl i_rdy (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (sof),
        .rd_clr (stat_rd),
        .rdy    (stack_rdy),
        .irq    (stack_irq)
    );

    // R2
    no_set_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !stack_rdy) |=> !stack_rdy);
endmodule

// File: tb/test_dlk_stack_tx.sv
`timescale 1ns/1ps
module test_dlk_stack_tx;
    import dlk_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic              host_wr;
    logic [ADDR_W-1:0] host_addr;
    logic [BYTE_W-1:0] host_wdata;
    logic              stat_rd;
    logic              frame_stb;
    logic [POS_W-1:0]  sf_pos;
    logic              ins_en;
    logic [2:0]        ins_mode;
    logic              fs_bit, fs_vld, stack_rdy, stack_irq;

    dlk_stack_tx i_dlk_stack_tx (.*);

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          done    = 0;

    stack_t             sh_m;
    logic [FS_BITS-1:0] cur_m;
    bit                 rdy_m, irq_m;

    // Reference ordering from R4, written independently of the package helper
    function automatic logic [FS_BITS-1:0] ref_seq(input stack_t s);
        return {s[0][5:0], s[1][5:0], s[2], s[3], s[4]};
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    // One clock: drive, advance, update model, compare
    task automatic step(input bit stb, input int pos, input bit we, input int wa,
                        input logic [7:0] wd, input bit rd, input string tag);
        bit act_m, sof_m, vld_m;
        logic bit_m;
        frame_stb  = stb;
        sf_pos     = POS_W'(pos);
        host_wr    = we;
        host_addr  = ADDR_W'(wa);
        host_wdata = wd;
        stat_rd    = rd;
        @(posedge clk);
        act_m = ins_en && (ins_mode[1:0] == 2'b10);
        sof_m = stb && act_m && (pos == 0);
        vld_m = stb && act_m && (pos % 2 == 0) && (pos < SF_FRAMES);
        if (sof_m) cur_m = ref_seq(sh_m);
        bit_m = cur_m[FS_BITS-1-pos/2];
        if (we && wa < REGS) sh_m[wa] = wd;
        if (sof_m) begin irq_m = !rdy_m; rdy_m = 1; end
        else begin irq_m = 0; if (rd) rdy_m = 0; end
        #1;
        chk(act_m ? tag : "R2", "fs_vld", fs_vld, vld_m);
        if (vld_m) chk(tag, "fs_bit", fs_bit, bit_m);
        chk(rd ? "R8" : "R7", "stack_rdy", stack_rdy, rdy_m);
        chk("R7", "stack_irq", stack_irq, irq_m);
        frame_stb = 0; host_wr = 0; stat_rd = 0;
    endtask

    task automatic gap(input string tag);
        step(0, 0, 0, 0, 8'h00, 0, tag);
        step(0, 0, 0, 0, 8'h00, 0, tag);
    endtask

    // Full superframe, optionally with random writes and reads
    task automatic superframe(input string tag, input bit rnd);
        for (int p = 0; p < SF_FRAMES; p++) begin
            if (rnd) begin
                step(1, p, ($urandom % 6) == 0, $urandom % 8, 8'($urandom),
                     ($urandom % 10) == 0, tag);
                step(0, 0, ($urandom % 3) == 0, $urandom % 8, 8'($urandom),
                     ($urandom % 12) == 0, tag);
            end else begin
                step(1, p, 0, 0, 8'h00, 0, tag);
                gap(tag);
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; host_wr = 0; host_addr = '0; host_wdata = '0; stat_rd = 0;
        frame_stb = 0; sf_pos = '0; ins_en = 1; ins_mode = 3'b010;
        sh_m = {8'h1F, 8'h08, 8'h00, 8'h07, 8'h07};
        cur_m = ref_seq(sh_m); rdy_m = 0; irq_m = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "stack_rdy", stack_rdy, 1'b0);
        chk("R1", "stack_irq", stack_irq, 1'b0);
        chk("R1", "fs_vld", fs_vld, 1'b0);
        rst_n = 1;

        // R1: idle default sequence on the first superframe
        superframe("R1", 0);

        // R4: program every byte, sent next superframe in byte/bit order
        step(0, 0, 1, 0, 8'h07, 0, "R4");
        step(0, 0, 1, 1, 8'h07, 0, "R4");
        step(0, 0, 1, 2, 8'hC3, 0, "R4");
        step(0, 0, 1, 3, 8'h5A, 0, "R4");
        step(0, 0, 1, 4, 8'h96, 0, "R4");
        superframe("R4", 0);

        // R6: write in the capture cycle and mid-superframe; retransmit afterwards
        step(1, 0, 1, 2, 8'hA5, 1, "R6");
        for (int p = 1; p < SF_FRAMES; p++) begin
            step(1, p, p == 30, 3, 8'h3C, 0, "R6");
        end
        superframe("R6", 0);
        superframe("R6", 0);

        // R5: writes to unused indices change nothing
        step(0, 0, 1, 5, 8'hFF, 0, "R5");
        step(0, 0, 1, 6, 8'hFF, 0, "R5");
        step(0, 0, 1, 7, 8'hFF, 0, "R5");
        superframe("R5", 0);

        // R8: read alone clears; read with the set keeps it set
        step(0, 0, 0, 0, 8'h00, 1, "R8");
        step(1, 0, 0, 0, 8'h00, 1, "R8");
        step(1, 0, 0, 0, 8'h00, 1, "R8");
        step(0, 0, 0, 0, 8'h00, 1, "R8");

        // R2: inactive settings, then bit 2 of mode as don't-care
        ins_en = 0; superframe("R2", 0);
        ins_en = 1; ins_mode = 3'b011; superframe("R2", 0);
        ins_mode = 3'b110; superframe("R3", 0);

        // R3: random traffic over several superframes
        for (int s = 0; s < 8; s++) begin
            ins_en = ($urandom % 5) != 0;
            ins_mode = (($urandom % 3) == 0) ? 3'($urandom) : {1'($urandom), 2'b10};
            superframe("R3", 1);
        end
        ins_en = 1; ins_mode = 3'b010;
        superframe("R6", 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule